// File: doc/BRIEF.md
# Masked vector lane unit

This unit runs one vector operation across a set of integer lanes and hands back a single destination vector one clock later. Each lane computes either a multiply-add or a simple two-operand operation on its elements of three source vectors. A per-lane predicate then decides what that lane delivers. The predicate comes from a mask register whose contents are supplied with the operation.

Where the predicate is clear, a lane passes on its first source element. The old destination value is never an input. A mode flag in the mask register's own contents can turn this merge into zeroing. The operation also carries an active length. Lanes at or above that length are cleared, so a scalar is simply a vector of length one. A mask selector of zero runs the operation unpredicated.

Top module: `vmask_lane_unit`

## Requirements
- R1: With `op` = 0 (multiply-add), each predicated-on active lane outputs `src1 + src2 * src3`, taken modulo 2^EW on that lane's EW-bit elements.
- R2: With `op` = 1 a lane computes `src1 + src2`, with `op` = 2 `src1 - src2`, and with `op` = 3 `src1 ^ src2`, all modulo 2^EW.
- R3: With a nonzero `mask_sel` and the mode flag clear, an active lane whose predicate bit is 0 outputs its `src1` element unchanged. The predicate bit for lane i is bit i*EW of `mask_data`, which is bit 0 of mask element i.
- R4: The mode flag is bit EW-1 of `mask_data`, the top bit of mask element 0. When it is set and `mask_sel` is nonzero, an active lane whose predicate bit is 0 outputs zero.
- R5: When `mask_sel` is 0, every active lane outputs its computed result, whatever `mask_data` holds, including a set mode flag.
- R6: A lane whose index is at or above `vlen` outputs zero. `vlen` = 0 clears every lane, and a `vlen` above LANES leaves every lane active.
- R7: `out_valid` is `in_valid` delayed by one clock. `out_vec` updates only on a clock where `in_valid` is high and holds its value otherwise.
- R8: While `rst_n` is low, `out_valid` is 0 and `out_vec` is all zeros.
- R9: With `vlen` = 1 the operation is a scalar operation: only lane 0 carries a value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | Operation code: 0 multiply-add, 1 add, 2 subtract, 3 xor |
| vlen | input | $clog2(LANES+1) | Active vector length in elements |
| mask_sel | input | 3 | Mask register number, 1 to 7; 0 means unpredicated |
| mask_data | input | LANES*EW | Contents of the selected mask register |
| src1 | input | LANES*EW | First source vector, also the merge value |
| src2 | input | LANES*EW | Second source vector |
| src3 | input | LANES*EW | Third source vector, the multiplicand for multiply-add |
| out_valid | output | 1 | Result present |
| out_vec | output | LANES*EW | Destination vector |

## Verification
An operation presented on a clock edge shows up on `out_vec` and `out_valid` after exactly that one edge, because a single register stage sits between the inputs and the outputs. The bench drives each operation on a falling edge and compares the outputs on the next falling edge, half a period after the capturing edge. On cycles with `in_valid` low, the bench changes the sources and checks one falling edge later that `out_valid` has dropped and that `out_vec` still holds the previous result.

// File: rtl/vml_pkg.sv
package vml_pkg;
  typedef enum logic [1:0] {
    OP_FMA = 2'd0,
    OP_ADD = 2'd1,
    OP_SUB = 2'd2,
    OP_XOR = 2'd3
  } vml_op_e;
endpackage

// File: rtl/vml_alu.sv
// Per-lane arithmetic: a + b*c or a two-operand operation, modulo 2^EW.
module vml_alu
  import vml_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] c,
  input  vml_op_e       op,
  output logic [EW-1:0] y
);
  always_comb begin
    unique case (op)
      OP_FMA:  y = a + EW'(b * c);
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_XOR:  y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/vml_select.sv
// Per-lane output choice: result, first source, or zero.
module vml_select #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] res,
  input  logic [EW-1:0] a,
  input  logic          active,
  input  logic          predicated,
  input  logic          pred_bit,
  input  logic          zero_mode,
  output logic [EW-1:0] y
);
  always_comb begin
    if (!active)                       y = '0;
    else if (!predicated || pred_bit)  y = res;
    else if (zero_mode)                y = '0;
    else                               y = a;
  end
endmodule

// File: rtl/vmask_lane_unit.sv
module vmask_lane_unit
  import vml_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EW    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [1:0]                   op,
  input  logic [$clog2(LANES+1)-1:0]   vlen,
  input  logic [2:0]                   mask_sel,
  input  logic [LANES*EW-1:0]          mask_data,
  input  logic [LANES*EW-1:0]          src1,
  input  logic [LANES*EW-1:0]          src2,
  input  logic [LANES*EW-1:0]          src3,
  output logic                         out_valid,
  output logic [LANES*EW-1:0]          out_vec
);
  localparam int VW       = LANES * EW;
  localparam int VLW      = $clog2(LANES + 1);
  localparam int MODE_BIT = EW - 1;

  vml_op_e           op_e;
  logic              predicated;
  logic              zero_mode;
  logic [EW-1:0]     res [LANES];
  logic [LANES-1:0]  active;
  logic [VW-1:0]     lane_y;
  logic [VW-1:0]     mask_unused;

  logic [VW-1:0]     vec_d, vec_q;
  logic              vld_d, vld_q;

  assign op_e        = vml_op_e'(op);
  assign predicated  = (mask_sel != 3'd0);
  assign zero_mode   = mask_data[MODE_BIT];
  assign mask_unused = mask_data;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign active[g] = (VLW'(g) < vlen);

    vml_alu #(.EW(EW)) u_alu (
      .a  (src1[g*EW +: EW]),
      .b  (src2[g*EW +: EW]),
      .c  (src3[g*EW +: EW]),
      .op (op_e),
      .y  (res[g])
    );

    vml_select #(.EW(EW)) u_sel (
      .res        (res[g]),
      .a          (src1[g*EW +: EW]),
      .active     (active[g]),
      .predicated (predicated),
      .pred_bit   (mask_data[g*EW]),
      .zero_mode  (zero_mode),
      .y          (lane_y[g*EW +: EW])
    );
  end

  // next state
  always_comb begin
    vld_d = in_valid;
    vec_d = vec_q;
    if (in_valid) vec_d = lane_y;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign out_valid = vld_q;
  assign out_vec   = vec_q;
endmodule

// File: rtl/vmask_lane_unit_chk.sv
module vmask_lane_unit_chk #(
  parameter int LANES = 4,
  parameter int EW    = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic [$clog2(LANES+1)-1:0] vlen,
  input logic [2:0]                 mask_sel,
  input logic [LANES*EW-1:0]        mask_data,
  input logic [LANES*EW-1:0]        src1,
  input logic                       out_valid,
  input logic [LANES*EW-1:0]        out_vec
);
  localparam int VW  = LANES * EW;
  localparam int VLW = $clog2(LANES + 1);

  logic [LANES-1:0] act_q, off_q;
  logic             zero_q;
  logic [VW-1:0]    src1_q;
  logic [VW-1:0]    chk_unused;

  assign chk_unused = mask_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      off_q  <= '0;
      zero_q <= 1'b0;
      src1_q <= '0;
    end else if (in_valid) begin
      for (int i = 0; i < LANES; i++) begin
        act_q[i] <= (VLW'(i) < vlen);
        off_q[i] <= (VLW'(i) < vlen) && (mask_sel != 3'd0) && !mask_data[i*EW];
      end
      zero_q <= mask_data[EW-1];
      src1_q <= src1;
    end
  end

  p_valid_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_vec));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_tail_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !act_q[g]) |-> (out_vec[g*EW +: EW] == '0));
    p_zeroing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && off_q[g] && zero_q) |-> (out_vec[g*EW +: EW] == '0));
    p_merge_src1_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && off_q[g] && !zero_q) |-> (out_vec[g*EW +: EW] == src1_q[g*EW +: EW]));
  end
endmodule

bind vmask_lane_unit vmask_lane_unit_chk #(.LANES(LANES), .EW(EW)) u_chk (.*);

// File: tb/vmask_lane_unit_tb.sv
`timescale 1ns/1ps
module vmask_lane_unit_tb;
  localparam int LANES = 4;
  localparam int EW    = 16;
  localparam int VW    = LANES * EW;
  localparam int VLW   = $clog2(LANES + 1);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [1:0]     op;
  logic [VLW-1:0] vlen;
  logic [2:0]     mask_sel;
  logic [VW-1:0]  mask_data, src1, src2, src3;
  logic           out_valid;
  logic [VW-1:0]  out_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  vmask_lane_unit #(.LANES(LANES), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .vlen(vlen),
    .mask_sel(mask_sel), .mask_data(mask_data), .src1(src1), .src2(src2),
    .src3(src3), .out_valid(out_valid), .out_vec(out_vec)
  );

  function automatic logic [VW-1:0] model(logic [1:0] o, logic [VLW-1:0] vl,
      logic [2:0] sel, logic [VW-1:0] md, logic [VW-1:0] a,
      logic [VW-1:0] b, logic [VW-1:0] c);
    logic [VW-1:0] r = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [EW-1:0] x, y, z, v;
      x = a[i*EW +: EW]; y = b[i*EW +: EW]; z = c[i*EW +: EW];
      case (o)
        2'd0: v = x + y * z;
        2'd1: v = x + y;
        2'd2: v = x - y;
        default: v = x ^ y;
      endcase
      if (i >= int'(vl)) v = '0;
      else if (sel != 0 && !md[i*EW]) v = md[EW-1] ? '0 : x;
      r[i*EW +: EW] = v;
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] mk_mask(logic [LANES-1:0] bits, logic zero);
    logic [VW-1:0] m = '0;
    for (int i = 0; i < LANES; i++) m[i*EW] = bits[i];
    m[EW-1] = zero;
    return m;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom(), $urandom()};
  endfunction

  task automatic chk(bit ok, string req, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [1:0] o, logic [VLW-1:0] vl,
      logic [2:0] sel, logic [VW-1:0] md, logic [VW-1:0] a,
      logic [VW-1:0] b, logic [VW-1:0] c);
    logic [VW-1:0] exp;
    exp = model(o, vl, sel, md, a, b, c);
    op = o; vlen = vl; mask_sel = sel; mask_data = md;
    src1 = a; src2 = b; src3 = c; in_valid = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b1, {req, " R7 valid"}, VW'(out_valid), VW'(1));
    chk(out_vec === exp, req, out_vec, exp);
    in_valid = 1'b0;
  endtask

  task automatic idle_hold();
    logic [VW-1:0] prev;
    prev = out_vec;
    src1 = rnd_vec(); src2 = rnd_vec(); src3 = rnd_vec();
    mask_data = rnd_vec(); in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7 valid drop", VW'(out_valid), VW'(0));
    chk(out_vec === prev, "R7 hold", out_vec, prev);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [VW-1:0] a, b, c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; vlen = '0; mask_sel = '0;
    mask_data = '0; src1 = '0; src2 = '0; src3 = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R8 reset valid", VW'(out_valid), VW'(0));
    chk(out_vec === '0, "R8 reset data", out_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);

    a = 64'h0004_0003_0002_0001;
    b = 64'h0010_0100_1000_FFFF;
    c = 64'h0002_0003_0004_0005;
    // R1 multiply-add, unpredicated, all lanes active, with wrap in lane 0
    run_op("R1 fma", 2'd0, 3'd4, 3'd0, '0, a, b, c);
    // R2 each two-operand operation
    run_op("R2 add", 2'd1, 3'd4, 3'd0, '0, a, b, c);
    run_op("R2 sub", 2'd2, 3'd4, 3'd0, '0, a, b, c);
    run_op("R2 xor", 2'd3, 3'd4, 3'd0, '0, a, b, c);
    idle_hold();
    // R3 merge with first source on predicate-off lanes
    run_op("R3 merge", 2'd0, 3'd4, 3'd3, mk_mask(4'b1010, 1'b0), a, b, c);
    run_op("R3 merge none", 2'd1, 3'd4, 3'd7, mk_mask(4'b0000, 1'b0), a, b, c);
    // R4 zeroing selected by mask contents
    run_op("R4 zeroing", 2'd0, 3'd4, 3'd1, mk_mask(4'b0110, 1'b1), a, b, c);
    // R5 selector zero ignores mask contents
    run_op("R5 unmasked", 2'd0, 3'd4, 3'd0, mk_mask(4'b0000, 1'b1), a, b, c);
    // R6 length handling
    run_op("R6 vlen2", 2'd1, 3'd2, 3'd0, '0, a, b, c);
    run_op("R6 vlen0", 2'd1, 3'd0, 3'd0, '0, a, b, c);
    run_op("R6 vlen7", 2'd1, 3'd7, 3'd2, mk_mask(4'b1100, 1'b0), a, b, c);
    // R9 scalar
    run_op("R9 scalar", 2'd0, 3'd1, 3'd0, '0, a, b, c);
    idle_hold();

    for (int n = 0; n < 400; n++) begin
      logic [2:0] sel;
      sel = ($urandom_range(0, 3) == 0) ? 3'd0 : 3'($urandom_range(1, 7));
      run_op("R1 R3 R4 R6 random", 2'($urandom_range(0, 3)),
             VLW'($urandom_range(0, 7)), sel,
             ($urandom_range(0, 1) == 1) ? rnd_vec() : mk_mask(4'($urandom), 1'($urandom)),
             rnd_vec(), rnd_vec(), rnd_vec());
      if ($urandom_range(0, 4) == 0) idle_hold();
    end

    done = 1;
    finish_run();
  end
endmodule